// File: doc/BRIEF.md
# Parallel Flash Byte-Program Sequencer

This block turns one request into the full bus-cycle sequence that programs a single byte into an external parallel NOR flash. A request carries an 18-bit target address, an 8-bit data value and a hold count. The block then plays four write cycles on the flash bus. The first three are the fixed unlock-and-program command prefix and the fourth writes the requested byte.

Every write cycle has two phases. In the setup phase, address and data are on the bus with write-enable high. In the strobe phase, the same values stay on the bus with write-enable low. A trailing phase with write-enable high ends the sequence, so the flash sees the rising edge of write-enable while the target address and data are still held. Each phase lasts for the hold count plus one clocks. Chip-enable stays low and output-enable stays high while the sequence runs. The block drives the data lines only during that time. Polling for completion is left to other logic.

Top module: `flash_prog_seq`

## Requirements
- R1: While reset is asserted, and while the block is idle afterwards, fl_ce_n, fl_oe_n and fl_we_n are 1, fl_dq_oe is 0, req_ready is 1 and done is 0.
- R2: A request is accepted on a rising clock edge where req_valid and req_ready are both 1. From the next clock, req_ready stays 0 until the sequence ends.
- R3: The four bus cycles present address/data in this order: 0x05555/0xAA, 0x02AAA/0x55, 0x05555/0xA0, then the requested address and data.
- R4: Each bus cycle is a setup phase with fl_we_n = 1, followed by a strobe phase with fl_we_n = 0 and the same address and data.
- R5: After the strobe of the target write, one more phase with fl_we_n = 1 keeps the target address and data on the bus.
- R6: Every one of the nine phases lasts hold_cycles+1 clocks, using the hold_cycles value sampled at acceptance.
- R7: While a sequence runs (req_ready = 0), fl_ce_n is 0, fl_oe_n is 1 and fl_dq_oe is 1.
- R8: done is a one-clock pulse. It appears in the first clock in which req_ready is back at 1, which is 9*(hold_cycles+1) clocks after acceptance.
- R9: Changes on req_addr, req_data and hold_cycles after acceptance have no effect on the running sequence.
- R10: With hold_cycles = 0, each phase lasts exactly one clock.
- R11: Asserting reset during a sequence returns every output to the R1 idle state at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Program request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_addr | input | 18 | Target flash address |
| req_data | input | 8 | Byte to program |
| hold_cycles | input | 8 | Extra clocks per phase (phase length = value+1) |
| done | output | 1 | One-clock pulse at the end of a sequence |
| fl_addr | output | 18 | Flash address bus |
| fl_dq_out | output | 8 | Flash data bus output value |
| fl_dq_oe | output | 1 | Data bus driver enable |
| fl_ce_n | output | 1 | Flash chip-enable, active low |
| fl_oe_n | output | 1 | Flash output-enable, active low |
| fl_we_n | output | 1 | Flash write-enable, active low |

## Verification
The assertions assume that reset is held from time zero until the clock runs, so past values that their edge functions use are never undefined. They also assume that req_valid is driven to a known level in every clock. The bench drives requests only on falling edges while the block reports ready, and it scrambles the request inputs right after acceptance. As a result, the stable-bus checks at write-enable falls rely only on the captured values and never on the live inputs.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;
   localparam int unsigned NUM_PHASES = 9;
   localparam int unsigned PH_W       = 4;
   localparam int unsigned CMD_W      = 8;
   localparam logic [15:0] UNLK_ADDR_FIRST  = 16'h5555;
   localparam logic [15:0] UNLK_ADDR_SECOND = 16'h2AAA;
   localparam logic [CMD_W-1:0] UNLK_DATA_FIRST  = 8'hAA;
   localparam logic [CMD_W-1:0] UNLK_DATA_SECOND = 8'h55;
   localparam logic [CMD_W-1:0] CMD_BYTE_PROG    = 8'hA0;
endpackage

// File: rtl/flash_hold_timer.sv
module flash_hold_timer #(
   parameter int unsigned HOLD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [HOLD_W-1:0] load_val,
   input  logic              run,
   output logic              expire
);
   logic [HOLD_W-1:0] hold_q;
   logic [HOLD_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         cnt_q  <= '0;
      end else if (load) begin
         hold_q <= load_val;
         cnt_q  <= load_val;
      end else if (run) begin
         if (cnt_q == '0) cnt_q <= hold_q;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expire = run && (cnt_q == '0);
endmodule

// File: rtl/flash_phase_ctr.sv
module flash_phase_ctr
   import flash_prog_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            step,
   output logic [PH_W-1:0] phase,
   output logic            busy,
   output logic            fin
);
   localparam logic [PH_W-1:0] LAST_PH = PH_W'(NUM_PHASES - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= '0;
         busy  <= 1'b0;
         fin   <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (start) begin
            phase <= '0;
            busy  <= 1'b1;
         end else if (busy && step) begin
            if (phase == LAST_PH) begin
               busy  <= 1'b0;
               fin   <= 1'b1;
               phase <= '0;
            end else begin
               phase <= phase + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/flash_bus_mux.sv
module flash_bus_mux
   import flash_prog_pkg::*;
#(
   parameter int unsigned ADDR_W = 18,
   parameter int unsigned DATA_W = 8
) (
   input  logic [PH_W-1:0]   phase,
   input  logic              busy,
   input  logic [ADDR_W-1:0] tgt_addr,
   input  logic [DATA_W-1:0] tgt_data,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_data,
   output logic              bus_we_n,
   output logic              bus_ce_n,
   output logic              bus_oe_n,
   output logic              bus_dq_oe
);
   localparam int unsigned CYC_W = PH_W - 1;

   logic [ADDR_W-1:0] addr_a, addr_b;
   logic [CYC_W-1:0]  cyc;

   generate
      if (ADDR_W > 16) begin : g_addr_wide
         assign addr_a = {{(ADDR_W-16){1'b0}}, UNLK_ADDR_FIRST};
         assign addr_b = {{(ADDR_W-16){1'b0}}, UNLK_ADDR_SECOND};
      end else begin : g_addr_exact
         assign addr_a = UNLK_ADDR_FIRST[ADDR_W-1:0];
         assign addr_b = UNLK_ADDR_SECOND[ADDR_W-1:0];
      end
   endgenerate

   assign cyc = phase[PH_W-1:1];

   always_comb begin
      bus_addr  = '0;
      bus_data  = '0;
      bus_we_n  = 1'b1;
      bus_ce_n  = 1'b1;
      bus_oe_n  = 1'b1;
      bus_dq_oe = 1'b0;
      if (busy) begin
         bus_ce_n  = 1'b0;
         bus_dq_oe = 1'b1;
         bus_we_n  = ~phase[0];
         case (cyc)
            CYC_W'(0): begin bus_addr = addr_a; bus_data = UNLK_DATA_FIRST;  end
            CYC_W'(1): begin bus_addr = addr_b; bus_data = UNLK_DATA_SECOND; end
            CYC_W'(2): begin bus_addr = addr_a; bus_data = CMD_BYTE_PROG;    end
            default:   begin bus_addr = tgt_addr; bus_data = tgt_data;       end
         endcase
      end
   end
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
   import flash_prog_pkg::*;
#(
   parameter int unsigned ADDR_W = 18,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned HOLD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   input  logic [HOLD_W-1:0] hold_cycles,
   output logic              done,
   output logic [ADDR_W-1:0] fl_addr,
   output logic [DATA_W-1:0] fl_dq_out,
   output logic              fl_dq_oe,
   output logic              fl_ce_n,
   output logic              fl_oe_n,
   output logic              fl_we_n
);
   generate
      if (ADDR_W < 16) begin : g_bad_addr
         $error("ADDR_W must hold the 16-bit unlock addresses");
      end
      if (DATA_W != CMD_W) begin : g_bad_data
         $error("DATA_W must equal the command byte width");
      end
      if (HOLD_W < 1) begin : g_bad_hold
         $error("HOLD_W must be at least 1");
      end
   endgenerate

   logic              accept;
   logic              busy;
   logic              expire;
   logic [PH_W-1:0]   phase;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;

   assign req_ready = ~busy;
   assign accept    = req_valid & req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
      end else if (accept) begin
         addr_q <= req_addr;
         data_q <= req_data;
      end
   end

   flash_hold_timer #(.HOLD_W(HOLD_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (hold_cycles),
      .run      (busy),
      .expire   (expire)
   );

   flash_phase_ctr u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .start (accept),
      .step  (expire),
      .phase (phase),
      .busy  (busy),
      .fin   (done)
   );

   flash_bus_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
      .phase     (phase),
      .busy      (busy),
      .tgt_addr  (addr_q),
      .tgt_data  (data_q),
      .bus_addr  (fl_addr),
      .bus_data  (fl_dq_out),
      .bus_we_n  (fl_we_n),
      .bus_ce_n  (fl_ce_n),
      .bus_oe_n  (fl_oe_n),
      .bus_dq_oe (fl_dq_oe)
   );
endmodule

// File: rtl/flash_prog_seq_chk.sv
module flash_prog_seq_chk #(
   parameter int unsigned ADDR_W = 18,
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              done,
   input logic [ADDR_W-1:0] fl_addr,
   input logic [DATA_W-1:0] fl_dq_out,
   input logic              fl_dq_oe,
   input logic              fl_ce_n,
   input logic              fl_oe_n,
   input logic              fl_we_n
);
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (fl_ce_n && fl_oe_n && fl_we_n && !fl_dq_oe)); // R1

   AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready); // R2

   AST_STROBE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fl_we_n) |-> ($stable(fl_addr) && $stable(fl_dq_out))); // R4

   AST_BUSY_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |-> (!fl_ce_n && fl_oe_n && fl_dq_oe)); // R7

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8

   AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (req_ready && $past(!req_ready))); // R8

   AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_we_n |-> !req_ready); // R4
endmodule

bind flash_prog_seq flash_prog_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .done      (done),
   .fl_addr   (fl_addr),
   .fl_dq_out (fl_dq_out),
   .fl_dq_oe  (fl_dq_oe),
   .fl_ce_n   (fl_ce_n),
   .fl_oe_n   (fl_oe_n),
   .fl_we_n   (fl_we_n)
);

// File: tb/flash_prog_seq_bench.sv
module flash_prog_seq_bench;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 18;
   localparam int DW = 8;
   localparam int HW = 8;
   localparam int NVEC = 5;

   typedef struct packed {
      logic [AW-1:0] addr;
      logic [DW-1:0] data;
      logic [HW-1:0] hold;
   } vec_t;

   localparam vec_t VECS [NVEC] = '{
      '{addr: 18'h00000, data: 8'h00, hold: 8'd0},
      '{addr: 18'h3FFFF, data: 8'hFF, hold: 8'd3},
      '{addr: 18'h15555, data: 8'h5A, hold: 8'd1},
      '{addr: 18'h2AAAA, data: 8'hC3, hold: 8'd5},
      '{addr: 18'h00123, data: 8'h81, hold: 8'd0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_data = '0;
   logic [HW-1:0] hold_cycles = '0;
   logic          done;
   logic [AW-1:0] fl_addr;
   logic [DW-1:0] fl_dq_out;
   logic          fl_dq_oe, fl_ce_n, fl_oe_n, fl_we_n;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_prog_seq u_flash_prog_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_data(req_data), .hold_cycles(hold_cycles),
      .done(done), .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
      .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Idle bus word: {ready, done, ce_n, oe_n, we_n, dq_oe}
   task automatic check_idle(input string req);
      check(req, {58'd0, req_ready, done, fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe},
            {58'd0, 6'b101110});
   endtask

   function automatic logic [AW-1:0] exp_addr(input int p, input logic [AW-1:0] t);
      case (p / 2)
         0, 2:    return 18'h05555;
         1:       return 18'h02AAA;
         default: return t;
      endcase
   endfunction

   function automatic logic [DW-1:0] exp_data(input int p, input logic [DW-1:0] t);
      case (p / 2)
         0:       return 8'hAA;
         1:       return 8'h55;
         2:       return 8'hA0;
         default: return t;
      endcase
   endfunction

   // R9: inputs are scrambled right after acceptance
   task automatic run_seq(input vec_t v);
      @(negedge clk);
      req_valid = 1'b1; req_addr = v.addr; req_data = v.data; hold_cycles = v.hold;
      @(negedge clk);
      req_valid = 1'b0; req_addr = ~v.addr; req_data = ~v.data; hold_cycles = v.hold + 8'd2;
      for (int p = 0; p < 9; p++) begin
         for (int k = 0; k <= int'(v.hold); k++) begin
            // R3 R4 R5 R6 R7 R9 R10: full bus word each clock
            check("R3/R4/R5/R6/R7/R9 bus word",
                  {20'd0, req_ready, fl_ce_n, fl_oe_n, fl_dq_oe, fl_we_n, fl_addr, fl_dq_out, 7'd0, done},
                  {20'd0, 1'b0, 1'b0, 1'b1, 1'b1, (p % 2 == 0), exp_addr(p, v.addr),
                   exp_data(p, v.data), 7'd0, 1'b0});
            @(negedge clk);
         end
      end
      // R8: done in first ready clock; R2 ready back
      check("R8 done pulse with ready", {62'd0, req_ready, done}, {62'd0, 2'b11});
      @(negedge clk);
      check("R8 done one clock", {63'd0, done}, 64'd0);
   endtask

   initial begin
      #(CLK_PERIOD * 3 + 2);
      check_idle("R1 reset state");
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R1 idle after reset");

      for (int i = 0; i < NVEC; i++) run_seq(VECS[i]);

      // R10: hold 0 gives exactly 9 busy clocks
      @(negedge clk);
      req_valid = 1'b1; req_addr = 18'h0ABCD; req_data = 8'h3C; hold_cycles = 8'd0;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (8) @(negedge clk);
      check("R10 last phase of hold 0", {62'd0, req_ready, fl_we_n}, {62'd0, 2'b01});
      @(negedge clk);
      check("R10 back to ready after 9 clocks", {62'd0, req_ready, done}, {62'd0, 2'b11});

      // R11: reset in the middle of a sequence
      @(negedge clk);
      req_valid = 1'b1; hold_cycles = 8'd4;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (12) @(negedge clk);
      check("R11 busy before reset", {63'd0, req_ready}, 64'd0);
      rst_n = 1'b0;
      #1;
      check_idle("R11 reset mid-sequence");
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R1 idle after second reset");
      run_seq('{addr: 18'h20001, data: 8'h7E, hold: 8'd2});

      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         finished = 1'b1;
         total++; bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule